// File: doc/BRIEF.md
# Sixteen-Channel Multihit Pattern Unit

This block keeps per-channel hit state for a bank of front inputs. Each channel passes its input through a synchronizer and finds rising edges there. An edge counts as a hit unless the channel's input mask blocks it or the optional gate is closed. Each channel holds two hit flags in cascade. The first flag records one hit. The second flag records a further hit that arrives while the first is already set. Together the two flags tell apart no hit, one hit and two or more hits.

Channel outputs follow one of the two flag stages, chosen by the operating mode. A per-channel output mask suppresses the flag-driven output, and a force register can drive any output regardless of that mask. The block also drives a wired-OR of the channel outputs, which a control bit can disable, and an interrupt request built from the flags that the interrupt mask leaves enabled.

A bus decoder in front of the block turns bus cycles into a write strobe and a read strobe, each with a register select and a data word. Reads return their result one cycle after the strobe and mark it with a valid flag.

Top module: `hit_pattern_unit`

## Requirements
- R1: A hit sets the channel's first flag. A hit that arrives while the first flag is set also sets the second flag.
- R2: A read with select 3 returns all first flags, and a read with select 4 returns all second flags. Bit n is channel n. Data appears with rd_valid one cycle after rd_en.
- R3: A read with select 9 returns the first flags and then clears them. A read with select 10 does the same for the second flags. The other stage is left as it was.
- R4: A write with select 0 applies one hit to each channel whose data bit is 1. This ignores the input level, the input mask and the gate.
- R5: A read with select 2 returns the synchronized live input levels. The input mask has no effect on this read.
- R6: A channel whose bit is 1 in the input mask (select 1, read/write) gets no hits from its input.
- R7: Control bit 0 (select 11) enables the gate. When it is 1, input edges count only while gate_in is high. When it is 0, which is the default, gate_in has no effect.
- R8: Control bit 2 selects the mode. When it is 0, ch_out[n] follows the first flag. When it is 1, ch_out[n] follows the second flag.
- R9: A 1 in the output mask (select 6) suppresses the flag-driven output of that channel. A 1 in the output force register (select 5) drives that output high regardless of the mask. A write with select 8 clears the force register.
- R10: or_out is high when any ch_out is high, unless control bit 1 is 1.
- R11: irq is high when any channel that is clear in the interrupt mask (select 7) has its mode-selected flag set.
- R12: Reset, and any write with select 12, return every flag, mask, force bit and control bit to 0.
- R13: Only the rising edge of an input counts, so a pulse held for many cycles is one hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_in | input | 16 | Asynchronous front inputs |
| gate_in | input | 1 | Asynchronous gate input |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Write register select |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 4 | Read register select |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | rd_data valid |
| ch_out | output | 16 | Channel outputs |
| or_out | output | 1 | Wired-OR of channel outputs |
| irq | output | 1 | Interrupt request |

## Verification
A level change on ch_in sets a flag three clock edges later: two synchronizer stages and then the flag register. The change reaches ch_out, or_out and irq one edge after that. The bench therefore waits six cycles after every input change before it reads or samples anything. A register write changes ch_out, or_out and irq on the next edge, and every read result comes one edge after its strobe. The driver task puts the expected read word in a queue when it issues the strobe. A monitor, running on the falling edge, takes that word off the queue in the cycle that rd_valid is high and compares it there. Output checks come two cycles after the write that caused them, so every register on the path has already updated.

// File: rtl/hpu_pkg.sv
package hpu_pkg;
  typedef enum logic [3:0] {
    SEL_HIT_INJECT  = 4'd0,
    SEL_IN_MASK     = 4'd1,
    SEL_IN_LEVEL    = 4'd2,
    SEL_FIRST       = 4'd3,
    SEL_SECOND      = 4'd4,
    SEL_OUT_FORCE   = 4'd5,
    SEL_OUT_MASK    = 4'd6,
    SEL_IRQ_MASK    = 4'd7,
    SEL_FORCE_CLR   = 4'd8,
    SEL_FIRST_CLR   = 4'd9,
    SEL_SECOND_CLR  = 4'd10,
    SEL_CTRL        = 4'd11,
    SEL_SOFT_RST    = 4'd12
  } sel_e;

  localparam int CTRL_W      = 3;
  localparam int CTRL_GATE   = 0;
  localparam int CTRL_OR_OFF = 1;
  localparam int CTRL_MULTI  = 2;
endpackage

// File: rtl/hpu_sync.sv
module hpu_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hpu_channel.sv
module hpu_channel (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic blocked,
  input  logic gate_ok,
  input  logic inject,
  input  logic clr_first,
  input  logic clr_second,
  output logic first,
  output logic second
);
  logic prev;
  logic hit;

  assign hit = (level & ~prev & ~blocked & gate_ok) | inject;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= 1'b0;
      first  <= 1'b0;
      second <= 1'b0;
    end else begin
      prev <= level;
      if (clr_first)  first <= 1'b0;
      else if (hit)   first <= 1'b1;
      if (clr_second)          second <= 1'b0;
      else if (hit && first)   second <= 1'b1;
    end
  end

  p_second_after_first_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(second) |-> $past(first));

  p_blocked_no_hit_r6: assert property (@(posedge clk) disable iff (rst)
    (blocked && !inject) |=> !$rose(first));

  p_clear_second_r3: assert property (@(posedge clk) disable iff (rst)
    clr_second |=> !second);
endmodule

// File: rtl/hit_pattern_unit.sv
module hit_pattern_unit
  import hpu_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int SEL_W    = 4,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   ch_in,
  input  logic             gate_in,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NCH-1:0]   wr_data,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [NCH-1:0]   rd_data,
  output logic             rd_valid,
  output logic [NCH-1:0]   ch_out,
  output logic             or_out,
  output logic             irq
);
  localparam int PAD_W = NCH - CTRL_W;

  logic [NCH-1:0]    lvl;
  logic              gate_s;
  logic [NCH-1:0]    in_mask, out_mask, out_force, irq_mask;
  logic [CTRL_W-1:0] ctrl;
  logic [NCH-1:0]    first, second, sel_flags, inject, out_next;
  logic              soft_rst, clr1, clr2, gate_ok;

  hpu_sync #(.W(NCH + 1), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst),
    .d({gate_in, ch_in}),
    .q({gate_s, lvl})
  );

  assign soft_rst = wr_en && (wr_sel == SEL_SOFT_RST);
  assign clr1     = (rd_en && (rd_sel == SEL_FIRST_CLR)) || soft_rst;
  assign clr2     = (rd_en && (rd_sel == SEL_SECOND_CLR)) || soft_rst;
  assign inject   = (wr_en && (wr_sel == SEL_HIT_INJECT)) ? wr_data : '0;
  assign gate_ok  = !ctrl[CTRL_GATE] || gate_s;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    hpu_channel u_ch (
      .clk(clk), .rst(rst),
      .level(lvl[n]), .blocked(in_mask[n]), .gate_ok(gate_ok),
      .inject(inject[n]), .clr_first(clr1), .clr_second(clr2),
      .first(first[n]), .second(second[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      in_mask   <= '0;
      out_mask  <= '0;
      out_force <= '0;
      irq_mask  <= '0;
      ctrl      <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_IN_MASK:   in_mask   <= wr_data;
        SEL_OUT_MASK:  out_mask  <= wr_data;
        SEL_OUT_FORCE: out_force <= wr_data;
        SEL_FORCE_CLR: out_force <= '0;
        SEL_IRQ_MASK:  irq_mask  <= wr_data;
        SEL_CTRL:      ctrl      <= wr_data[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (rd_sel)
          SEL_IN_MASK:    rd_data <= in_mask;
          SEL_IN_LEVEL:   rd_data <= lvl;
          SEL_FIRST,
          SEL_FIRST_CLR:  rd_data <= first;
          SEL_SECOND,
          SEL_SECOND_CLR: rd_data <= second;
          SEL_OUT_FORCE:  rd_data <= out_force;
          SEL_OUT_MASK:   rd_data <= out_mask;
          SEL_IRQ_MASK:   rd_data <= irq_mask;
          SEL_CTRL:       rd_data <= {{PAD_W{1'b0}}, ctrl};
          default:        rd_data <= '0;
        endcase
      end
    end
  end

  assign sel_flags = ctrl[CTRL_MULTI] ? second : first;
  assign out_next  = (sel_flags & ~out_mask) | out_force;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_out <= '0;
      or_out <= 1'b0;
      irq    <= 1'b0;
    end else begin
      ch_out <= out_next;
      or_out <= (|out_next) && !ctrl[CTRL_OR_OFF];
      irq    <= |(sel_flags & ~irq_mask);
    end
  end

  p_force_drives_r9: assert property (@(posedge clk) disable iff (rst)
    (|out_force) |=> ((ch_out & $past(out_force)) == $past(out_force)));

  p_or_disabled_r10: assert property (@(posedge clk) disable iff (rst)
    ctrl[CTRL_OR_OFF] |=> !or_out);

  p_irq_all_masked_r11: assert property (@(posedge clk) disable iff (rst)
    (&irq_mask) |=> !irq);
endmodule

// File: tb/hit_pattern_unit_test.sv
module hit_pattern_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] ch_in;
  logic        gate_in;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [15:0] wr_data;
  logic        rd_en;
  logic [3:0]  rd_sel;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [15:0] ch_out;
  logic        or_out;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  hit_pattern_unit uut (
    .clk(clk), .rst(rst), .ch_in(ch_in), .gate_in(gate_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid),
    .ch_out(ch_out), .or_out(or_out), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check("unexpected read result", rd_data, 16'hxxxx);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] sel, input logic [15:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int ch, input int width);
    @(negedge clk);
    ch_in[ch] = 1'b1;
    repeat (width) @(negedge clk);
    ch_in[ch] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; ch_in = '0; gate_in = 1'b0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_en = 1'b0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset ch_out", ch_out, 16'h0000);
    check("R12 reset or_out", {15'b0, or_out}, 16'h0000);
    check("R12 reset irq", {15'b0, irq}, 16'h0000);
    rd(4'd11, 16'h0000, "R12 reset control");

    pulse(0, 12);
    rd(4'd3, 16'h0001, "R13 long pulse first flag");
    rd(4'd4, 16'h0000, "R13 long pulse single hit");
    pulse(0, 2);
    rd(4'd4, 16'h0001, "R1 R2 second hit sets second flag");
    check("R8 single mode output", ch_out, 16'h0001);
    check("R10 or active", {15'b0, or_out}, 16'h0001);
    check("R11 irq on first flag", {15'b0, irq}, 16'h0001);

    rd(4'd10, 16'h0001, "R3 second read-clear value");
    rd(4'd4, 16'h0000, "R3 second stage cleared");
    rd(4'd3, 16'h0001, "R3 first stage kept");
    rd(4'd9, 16'h0001, "R3 first read-clear value");
    rd(4'd3, 16'h0000, "R3 first stage cleared");

    wr(4'd11, 16'h0004);
    pulse(1, 3);
    check("R8 multihit mode one hit no output", ch_out, 16'h0000);
    pulse(1, 3);
    check("R8 multihit mode two hits output", ch_out, 16'h0002);
    check("R11 irq on second flag", {15'b0, irq}, 16'h0001);

    wr(4'd1, 16'h0004);
    pulse(2, 3);
    rd(4'd3, 16'h0002, "R6 masked channel no hit");
    @(negedge clk); ch_in[2] = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd2, 16'h0004, "R5 level read ignores mask");
    ch_in[2] = 1'b0;
    repeat (4) @(negedge clk);

    wr(4'd11, 16'h0005);
    gate_in = 1'b0;
    repeat (4) @(negedge clk);
    pulse(3, 3);
    rd(4'd3, 16'h0002, "R7 closed gate blocks hit");
    gate_in = 1'b1;
    repeat (4) @(negedge clk);
    pulse(3, 3);
    rd(4'd3, 16'h000A, "R7 open gate accepts hit");

    wr(4'd0, 16'h0010);
    rd(4'd3, 16'h001A, "R4 inject sets first flag");
    wr(4'd0, 16'h0010);
    rd(4'd4, 16'h0012, "R4 second inject sets second flag");
    settle();
    check("R8 multihit outputs", ch_out, 16'h0012);

    wr(4'd6, 16'h0002);
    settle();
    check("R9 output mask", ch_out, 16'h0010);
    wr(4'd5, 16'h0022);
    settle();
    check("R9 force overrides mask", ch_out, 16'h0032);
    wr(4'd8, 16'h0000);
    settle();
    check("R9 force cleared", ch_out, 16'h0010);

    check("R10 or before disable", {15'b0, or_out}, 16'h0001);
    wr(4'd11, 16'h0007);
    settle();
    check("R10 or disabled", {15'b0, or_out}, 16'h0000);

    wr(4'd7, 16'hFFED);
    settle();
    check("R11 irq with enabled flagged channel", {15'b0, irq}, 16'h0001);
    wr(4'd7, 16'hFFFF);
    settle();
    check("R11 irq all masked", {15'b0, irq}, 16'h0000);

    wr(4'd12, 16'h0000);
    settle();
    rd(4'd11, 16'h0000, "R12 soft reset control");
    rd(4'd3, 16'h0000, "R12 soft reset first flags");
    rd(4'd4, 16'h0000, "R12 soft reset second flags");
    rd(4'd1, 16'h0000, "R12 soft reset input mask");
    check("R12 soft reset outputs", ch_out, 16'h0000);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("read results missing", 16'(exp_q.size()), 16'h0000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 16'h0001, 16'h0000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule